// File: doc/BRIEF.md
# Addressed Asynchronous Serial Link

This block pairs an asynchronous serial transmitter with a receiver. Both use a frame that carries one extra flag bit after the data byte. When the flag is 1 the byte is a station address. When it is 0 the byte is payload. Several stations share one line. A sender first puts an address frame on the line to pick a station, then sends payload frames that only the picked station passes on. For example, to deliver 0xAA to station 0x01, it sends 0x01 with the flag set and then 0xAA with the flag clear.

The transmitter has a register-style front end: a one-byte holding register, an empty flag, the flag value for the next frame, and a transmit enable. Software writes the byte and its flag while the empty flag is 1, then clears the empty flag to hand the byte over. The holding register frees up as soon as the shifter takes the byte, so the next byte can be written while the current frame is still on the line. With transmit disabled, a port override can drive the line directly, for example low to send a break.

The receiver oversamples the line at 16 ticks per bit. It keeps a private "selected" state that every address frame updates, and it strobes out only payload frames that arrive while it is selected. The frame has no parity bit. A low stop bit is reported as a framing error.

Top module: `mp_serial_link`

## Requirements
- R1: While reset is asserted and right after it, the empty flag reads 1, the line output is high and the receiver emits no valid or error pulse. The receiver starts deselected.
- R2: A write is accepted only while the empty flag reads 1, and it captures the data byte and the flag bit together. A write made while the empty flag reads 0 is ignored and does not change the byte that is later sent.
- R3: Clearing the empty flag hands the byte over. The empty flag reads 0 from the next cycle. It returns to 1 in the cycle after the shifter loads the byte, which happens as soon as transmit is enabled and the shifter is idle. While a frame is on the line and a second byte is pending, the empty flag stays 0.
- R4: A frame is, in line order: start bit 0, then 8 data bits LSB first, then the flag bit, then stop bit 1. Each bit lasts 16 ticks. There is no parity bit.
- R5: With transmit enabled and no frame in progress, the line output is high.
- R6: With transmit disabled, the line output equals the port value when the override is 1, and is high when the override is 0. Holding the port value at 0 drives a break.
- R7: A received frame with flag 1 and a good stop bit makes the receiver selected if its byte equals the configured station ID, and deselected otherwise.
- R8: A received frame with flag 0 and a good stop bit raises the valid output for exactly one cycle, with the byte on the data output, but only if the receiver is selected. Address frames are never delivered.
- R9: A received frame whose stop bit is 0 gives a one-cycle error pulse. It is not delivered, it leaves the selection unchanged, and the receiver waits for the line to go high before it looks for a new start bit.
- R10: Payload frames sent back to back are delivered in the order they were written, with no byte lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling tick, 16 per bit time |
| wr_en | input | 1 | Write holding register (byte and flag) |
| wr_data | input | 8 | Byte to send |
| wr_mpb | input | 1 | Flag bit for the frame: 1 address, 0 payload |
| clr_empty | input | 1 | Clear the empty flag to start sending |
| tx_en | input | 1 | Transmit enable |
| port_ovr | input | 1 | Line override enable, used when transmit is disabled |
| port_val | input | 1 | Line level driven while the override is active |
| tx_empty | output | 1 | Holding register can accept a byte |
| txd | output | 1 | Serial line output |
| rxd | input | 1 | Serial line input |
| my_id | input | 8 | This station's address |
| rx_data | output | 8 | Delivered payload byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_ferr | output | 1 | One-cycle framing-error pulse |

## Verification
The assertions check, on every cycle, the local rules:
- the holding register is frozen while the empty flag is 0;
- a load refills the empty flag;
- each frame opens with a low start bit;
- the idle line is high;
- a delivery never happens while the receiver is deselected;
- an error pulse leaves the selection unchanged;
- the receiver stays parked while a break holds the line low.

Only the bench scenarios can show the end-to-end behaviour:
- the exact bit order and bit timing on the line;
- address filtering across a sequence of stations;
- a write made while the empty flag is 0 having no effect on what is sent;
- a break being seen as exactly one framing error;
- in-order delivery of back-to-back payload.

// File: rtl/mp_link_pkg.sv
package mp_link_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned FRAME_BITS = DATA_W + 3;

    typedef struct packed {
        logic              mpb;
        logic [DATA_W-1:0] data;
    } mp_word_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    // line order from bit 0: start, data LSB first, flag, stop
    function automatic logic [FRAME_BITS-1:0] build_frame(mp_word_t w);
        return {1'b1, w.mpb, w.data, 1'b0};
    endfunction

endpackage

// File: rtl/mp_tx.sv
module mp_tx import mp_link_pkg::*; #(
    parameter int unsigned OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     wr_en,
    input  mp_word_t wr_word,
    input  logic     clr_empty,
    input  logic     tx_en,
    input  logic     port_ovr,
    input  logic     port_val,
    output logic     empty,
    output logic     txd
);
    localparam int unsigned FB = FRAME_BITS;
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned BW = $clog2(FB + 1);

    mp_word_t        hold_q;
    logic            empty_q, busy_q;
    logic [FB-1:0]   sh_q;
    logic [CW-1:0]   tcnt_q;
    logic [BW-1:0]   bcnt_q;
    logic            load;

    assign load  = !empty_q && !busy_q && tx_en;
    assign empty = empty_q;
    assign txd   = tx_en ? sh_q[0] : (!port_ovr || port_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
            busy_q  <= 1'b0;
            sh_q    <= '1;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
        end else begin
            if (wr_en && empty_q)
                hold_q <= wr_word;
            if (load)
                empty_q <= 1'b1;
            else if (clr_empty)
                empty_q <= 1'b0;
            if (!tx_en) begin
                busy_q <= 1'b0;
                sh_q   <= '1;
                tcnt_q <= '0;
                bcnt_q <= '0;
            end else if (load) begin
                sh_q   <= build_frame(hold_q);
                busy_q <= 1'b1;
                tcnt_q <= '0;
                bcnt_q <= '0;
            end else if (busy_q && tick) begin
                if (tcnt_q == CW'(OSR - 1)) begin
                    tcnt_q <= '0;
                    sh_q   <= {1'b1, sh_q[FB-1:1]};
                    if (bcnt_q == BW'(FB - 1)) begin
                        busy_q <= 1'b0;
                        bcnt_q <= '0;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
        end
    end

    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !empty_q |=> $stable(hold_q)); // R2
    AST_LOAD_REFILLS: assert property (@(posedge clk) disable iff (rst)
        (!empty_q && !busy_q && tx_en) |=> (empty_q && busy_q)); // R3
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !txd); // R4
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !busy_q) |-> txd); // R5

endmodule

// File: rtl/mp_rx.sv
module mp_rx import mp_link_pkg::*; #(
    parameter int unsigned OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic [DATA_W-1:0] my_id,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr
);
    localparam int unsigned CW = $clog2(OSR);
    localparam int unsigned IW = $clog2(DATA_W + 1);

    logic              s1_q, line;
    rx_state_e         state_q;
    logic [CW-1:0]     tcnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W:0]   sh_q;
    mp_word_t          word;
    logic              sel_q, valid_q, ferr_q;
    logic [DATA_W-1:0] data_q;

    assign word     = mp_word_t'(sh_q);
    assign rx_data  = data_q;
    assign rx_valid = valid_q;
    assign rx_ferr  = ferr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b1;
            line    <= 1'b1;
            state_q <= RX_IDLE;
            tcnt_q  <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            sel_q   <= 1'b0;
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            s1_q    <= rxd;
            line    <= s1_q;
            valid_q <= 1'b0;
            ferr_q  <= 1'b0;
            case (state_q)
                RX_IDLE: if (!line) begin
                    state_q <= RX_START;
                    tcnt_q  <= '0;
                end
                RX_START: if (tick) begin
                    if (tcnt_q == CW'(OSR / 2 - 1)) begin
                        tcnt_q  <= '0;
                        idx_q   <= '0;
                        state_q <= line ? RX_IDLE : RX_BITS;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                RX_BITS: if (tick) begin
                    if (tcnt_q == CW'(OSR - 1)) begin
                        tcnt_q <= '0;
                        sh_q   <= {line, sh_q[DATA_W:1]};
                        if (idx_q == IW'(DATA_W))
                            state_q <= RX_STOP;
                        else
                            idx_q <= idx_q + 1'b1;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (tcnt_q == CW'(OSR - 1)) begin
                        tcnt_q <= '0;
                        if (line) begin
                            state_q <= RX_IDLE;
                            if (word.mpb) begin
                                sel_q <= (word.data == my_id);
                            end else if (sel_q) begin
                                data_q  <= word.data;
                                valid_q <= 1'b1;
                            end
                        end else begin
                            ferr_q  <= 1'b1;
                            state_q <= RX_HOLD;
                        end
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                RX_HOLD: if (line) state_q <= RX_IDLE;
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    AST_VALID_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> sel_q); // R8
    AST_FERR_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        ferr_q |-> !valid_q); // R9
    AST_FERR_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
        ferr_q |-> $stable(sel_q)); // R9
    AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_HOLD && !line) |=> (state_q == RX_HOLD)); // R9

endmodule

// File: rtl/mp_serial_link.sv
module mp_serial_link import mp_link_pkg::*; #(
    parameter int unsigned OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_mpb,
    input  logic              clr_empty,
    input  logic              tx_en,
    input  logic              port_ovr,
    input  logic              port_val,
    output logic              tx_empty,
    output logic              txd,
    input  logic              rxd,
    input  logic [DATA_W-1:0] my_id,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr
);
    mp_word_t wr_word;
    assign wr_word = '{mpb: wr_mpb, data: wr_data};

    mp_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst(rst), .tick(tick),
        .wr_en(wr_en), .wr_word(wr_word), .clr_empty(clr_empty),
        .tx_en(tx_en), .port_ovr(port_ovr), .port_val(port_val),
        .empty(tx_empty), .txd(txd)
    );

    mp_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .my_id(my_id),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, rx_ferr})); // R9

endmodule

// File: tb/mp_serial_link_test.sv
`timescale 1ns/1ps
module mp_serial_link_test;
    logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic wr_en = 1'b0, wr_mpb = 1'b0, clr_empty = 1'b0;
    logic tx_en = 1'b0, port_ovr = 1'b0, port_val = 1'b1;
    logic [7:0] wr_data = '0, my_id = 8'h02;
    logic tx_empty, txd, rxd, rx_valid, rx_ferr;
    logic [7:0] rx_data;

    int n_chk = 0, n_fail = 0, n_ferr = 0, n_unexp = 0;
    logic [7:0] exp_q[$];

    assign rxd = txd;

    always #2.5 clk = ~clk;
    initial forever begin @(negedge clk); tick = ~tick; end

    mp_serial_link uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .wr_mpb(wr_mpb), .clr_empty(clr_empty), .tx_en(tx_en),
        .port_ovr(port_ovr), .port_val(port_val), .tx_empty(tx_empty),
        .txd(txd), .rxd(rxd), .my_id(my_id), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic mpb, input logic deliver);
        while (!tx_empty) @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_mpb = mpb;
        @(negedge clk);
        wr_en = 1'b0; clr_empty = 1'b1;
        if (deliver) exp_q.push_back(d);
        @(negedge clk);
        clr_empty = 1'b0;
    endtask

    task automatic drain();
        while (!tx_empty) @(negedge clk);
        repeat (420) @(negedge clk);
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (!rst && rx_ferr) n_ferr++;
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                n_unexp++;
                check(1'b0, "R8 unexpected delivery", rx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R10 delivered byte", rx_data, e);
            end
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [10:0] frame;
        repeat (3) @(negedge clk);
        check(tx_empty == 1'b1, "R1 empty in reset", tx_empty, 1);
        check(txd == 1'b1, "R1 line high in reset", txd, 1);
        check(rx_valid == 1'b0 && rx_ferr == 1'b0, "R1 no rx pulse", rx_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_empty == 1'b1, "R1 empty after reset", tx_empty, 1);
        tx_en = 1'b1;
        repeat (4) @(negedge clk);
        check(txd == 1'b1, "R5 idle high", txd, 1);

        // ID 0x01 frame: check handover and line waveform
        send(8'h01, 1'b1, 1'b0);
        check(tx_empty == 1'b0, "R3 empty cleared", tx_empty, 0);
        @(negedge clk);
        check(tx_empty == 1'b1, "R3 empty refilled after load", tx_empty, 1);
        check(txd == 1'b0, "R4 start bit", txd, 0);
        frame = {1'b1, 1'b1, 8'h01, 1'b0};
        repeat (16) @(negedge clk);
        for (int k = 0; k < 11; k++) begin
            check(txd == frame[k], "R4 frame bit", txd, frame[k]);
            repeat (32) @(negedge clk);
        end

        // addressed to station 01: must not be delivered here (R7, R8)
        send(8'hAA, 1'b0, 1'b0);
        send(8'h02, 1'b1, 1'b0);
        send(8'h55, 1'b0, 1'b1);
        check(tx_empty == 1'b0, "R3 empty held while busy", tx_empty, 0);
        wr_en = 1'b1; wr_data = 8'h99; wr_mpb = 1'b1;   // ignored write, R2
        @(negedge clk);
        wr_en = 1'b0;
        send(8'h00, 1'b0, 1'b1);
        send(8'hFF, 1'b0, 1'b1);
        send(8'h03, 1'b1, 1'b0);
        send(8'h77, 1'b0, 1'b0);
        send(8'h02, 1'b1, 1'b0);
        send(8'h81, 1'b0, 1'b1);
        drain();
        check(exp_q.size() == 0, "R2 R10 all expected bytes delivered", exp_q.size(), 0);
        check(n_unexp == 0, "R7 R8 no foreign data delivered", n_unexp, 0);
        check(n_ferr == 0, "R9 no spurious error", n_ferr, 0);

        // break via port override
        tx_en = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R6 disabled no override high", txd, 1);
        port_ovr = 1'b1; port_val = 1'b0;
        @(negedge clk);
        check(txd == 1'b0, "R6 break drives low", txd, 0);
        repeat (600) @(negedge clk);
        check(n_ferr == 1, "R9 break gives one framing error", n_ferr, 1);
        check(txd == 1'b0, "R6 break held", txd, 0);
        port_val = 1'b1;
        repeat (40) @(negedge clk);
        check(txd == 1'b1, "R6 override high", txd, 1);
        port_ovr = 1'b0; tx_en = 1'b1;
        repeat (4) @(negedge clk);
        // selection kept through the errored frame
        send(8'h3C, 1'b0, 1'b1);
        drain();
        check(exp_q.size() == 0, "R9 selection kept after error", exp_q.size(), 0);
        check(n_ferr == 1, "R9 no extra error", n_ferr, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule